// File: doc/BRIEF.md
# Packet-to-Memory-Mapped Request Bridge

The bridge sits between a receive packet stream and a small set of memory-mapped target functions. Each incoming request is a single 128-bit beat that carries a header dword, a requester identifier dword, an address dword and a data dword. The bridge decodes the beat as a single-dword memory write or memory read, uses one address bit to pick one of the target functions, and drives that function's select together with a write or read strobe.

Writes finish silently once the strobe has been issued. Reads wait for the target's read-data-valid pulse, capture the returned dword and send it back as a one-beat completion packet on a separate transmit stream, which honours back-pressure. Beats that are not a recognised single-dword request are discarded without touching any target. The bridge handles one request at a time: it only offers to take a new beat while it is idle.

Top module: `pkt_mm_bridge`

## Requirements
- R1: `rx_ready` is high exactly while the bridge is idle; a beat is taken on a rising clock edge where `rx_valid`, `rx_ready` and `rx_sop` are all high.
- R2: Beat layout, dword n at bits [32n+31:32n]: dword 0 is the header with the format/type code in bits [31:24] and the remaining bits [23:0] equal to 1; dword 1 is the requester identifier and tag; dword 2 is the address, presented on `mm_addr` during the access; dword 3 is the write data.
- R3: Address bit 20 picks the target (0 picks function 0, 1 picks function 1); only bit f of `mm_sel`, `mm_wr` and `mm_rd` may be high for target f, and at most one bit of each is high.
- R4: A write (code 0x40) raises the target's `mm_sel` and `mm_wr` bits for exactly the one cycle after the taking edge, with dword 3 on `mm_wdata`; no completion is sent and `rx_ready` returns high the following cycle.
- R5: A read (code 0x00) raises the target's `mm_rd` bit for exactly the one cycle after the taking edge; the target's `mm_sel` bit stays high from that cycle until the edge that samples `mm_rdvalid`.
- R6: After the read strobe, the bridge waits any number of cycles and captures `mm_rdata` on the edge where `mm_rdvalid` is high; `mm_rdvalid` while no read is outstanding has no effect.
- R7: The completion is one beat with `tx_valid`, `tx_sop` and `tx_eop` high together in the cycle after the capturing edge; dword 0 is 0x4A000001 (code 0x4A, length 1), dword 1 is zero, dword 2 is the request's dword 1, dword 3 is the captured read data.
- R8: While `tx_ready` is low the completion beat stays valid and unchanged; it is retired on the edge where `tx_ready` is high, and `rx_ready` stays low until then.
- R9: A taken beat with an unknown code, with header bits [23:0] other than 1, or with `rx_eop` low is dropped: no strobe or select is raised and `rx_ready` remains high.
- R10: Synchronous active-high `rst` returns the bridge to idle with every select, strobe and `tx_valid` low and `rx_ready` high.
- R11: A beat offered with `rx_sop` low is ignored and causes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Bridge can take a request |
| rx_sop | input | 1 | Receive start of packet |
| rx_eop | input | 1 | Receive end of packet |
| rx_data | input | 128 | Receive beat |
| mm_sel | output | 2 | Per-function select |
| mm_wr | output | 2 | Per-function write strobe |
| mm_rd | output | 2 | Per-function read strobe |
| mm_addr | output | 32 | Access address |
| mm_wdata | output | 32 | Write data |
| mm_rdata | input | 32 | Read data from the selected function |
| mm_rdvalid | input | 1 | Read data valid pulse |
| tx_valid | output | 1 | Completion beat valid |
| tx_ready | input | 1 | Completion sink ready |
| tx_sop | output | 1 | Completion start of packet |
| tx_eop | output | 1 | Completion end of packet |
| tx_data | output | 128 | Completion beat |

## Verification
The bench aims at read latency of one and several cycles, a completion held under back-pressure for several cycles, stray read-valid pulses while idle, and beats that must be dropped (unknown code, wrong header length, missing end-of-packet, missing start-of-packet). A bridge that captured data early would send the wrong dword 3; one that let the beat drift under back-pressure or reopened `rx_ready` before retirement would lose or overlap transactions. A wrong address bit or a stale function index shows as the select of the other function, and a decoder that treated bad headers as reads would strobe a target that should stay quiet.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_READ,
      ST_WAIT,
      ST_CPL
   } pmb_state_e;

   typedef enum logic [1:0] {
      OP_WRITE,
      OP_READ,
      OP_DROP
   } pmb_op_e;

   localparam logic [7:0] CODE_MWR  = 8'h40;
   localparam logic [7:0] CODE_MRD  = 8'h00;
   localparam logic [7:0] CODE_CPLD = 8'h4A;
endpackage

// File: rtl/pmb_decode.sv
module pmb_decode
   import pmb_pkg::*;
#(
   parameter int DW       = 32,
   parameter int DATA_W   = 128,
   parameter int FSEL_BIT = 20,
   parameter int FIDX_W   = 1
) (
   input  logic [DATA_W-1:0] beat,
   input  logic              eop,
   output pmb_op_e           op,
   output logic [FIDX_W-1:0] fidx,
   output logic [DW-1:0]     tag,
   output logic [DW-1:0]     addr,
   output logic [DW-1:0]     wdata
);
   localparam int LOW_W = DW - 8;

   generate
      if (DATA_W != 4 * DW) begin : g_bad_width
         $error("pmb_decode: beat must hold exactly four dwords");
      end
      if (FSEL_BIT + FIDX_W > DW) begin : g_bad_fsel
         $error("pmb_decode: function index lies outside the address");
      end
   endgenerate

   logic [DW-1:0] hdr;
   logic [7:0]    code;
   logic          shape_ok;

   always_comb begin
      hdr      = beat[DW-1:0];
      tag      = beat[2*DW-1:DW];
      addr     = beat[3*DW-1:2*DW];
      wdata    = beat[4*DW-1:3*DW];
      code     = hdr[DW-1 -: 8];
      fidx     = addr[FSEL_BIT +: FIDX_W];
      shape_ok = eop && (hdr[LOW_W-1:0] == LOW_W'(1));
      if (!shape_ok)             op = OP_DROP;
      else if (code == CODE_MWR) op = OP_WRITE;
      else if (code == CODE_MRD) op = OP_READ;
      else                       op = OP_DROP;
   end
endmodule

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
   import pmb_pkg::*;
#(
   parameter int NFUNC  = 2,
   parameter int FIDX_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  pmb_op_e           op,
   input  logic [FIDX_W-1:0] fidx,
   input  logic              rd_valid,
   input  logic              tx_ready,
   output logic              idle,
   output logic              cap_req,
   output logic              cap_rd,
   output logic              cpl_valid,
   output logic [NFUNC-1:0]  sel_vec,
   output logic [NFUNC-1:0]  wr_vec,
   output logic [NFUNC-1:0]  rd_vec
);
   pmb_state_e        state_q;
   logic [FIDX_W-1:0] fidx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         fidx_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (take) begin
                  fidx_q <= fidx;
                  if (op == OP_WRITE)     state_q <= ST_WRITE;
                  else if (op == OP_READ) state_q <= ST_READ;
               end
            end
            ST_WRITE: state_q <= ST_IDLE;
            ST_READ:  state_q <= ST_WAIT;
            ST_WAIT:  if (rd_valid) state_q <= ST_CPL;
            ST_CPL:   if (tx_ready) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   logic busy_sel;

   always_comb begin
      idle      = (state_q == ST_IDLE);
      cap_req   = idle && take;
      cap_rd    = (state_q == ST_WAIT) && rd_valid;
      cpl_valid = (state_q == ST_CPL);
      busy_sel  = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_WAIT);
   end

   for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      logic hit;
      assign hit        = (fidx_q == FIDX_W'(f));
      assign sel_vec[f] = hit && busy_sel;
      assign wr_vec[f]  = hit && (state_q == ST_WRITE);
      assign rd_vec[f]  = hit && (state_q == ST_READ);
   end

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (|wr_vec) |=> !(|wr_vec)); // R4
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (|rd_vec) |=> !(|rd_vec)); // R5
   AST_SEL_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
      ((|rd_vec) && !rd_valid) |=> (sel_vec == $past(rd_vec))); // R5
endmodule

// File: rtl/pmb_cpl.sv
module pmb_cpl
   import pmb_pkg::*;
#(
   parameter int DW     = 32,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_req,
   input  logic              cap_rd,
   input  logic [DW-1:0]     tag_in,
   input  logic [DW-1:0]     addr_in,
   input  logic [DW-1:0]     wdata_in,
   input  logic [DW-1:0]     rdata_in,
   input  logic              cpl_valid,
   input  logic              tx_ready,
   output logic [DW-1:0]     addr_q,
   output logic [DW-1:0]     wdata_q,
   output logic [DATA_W-1:0] tx_data
);
   localparam int LOW_W = DW - 8;

   logic [DW-1:0] tag_q;
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (cap_req) begin
            tag_q   <= tag_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
         end
         if (cap_rd) rdata_q <= rdata_in;
      end
   end

   assign tx_data = {rdata_q, tag_q, {DW{1'b0}}, CODE_CPLD, LOW_W'(1)};

   AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cpl_valid && !tx_ready) |=> (cpl_valid && $stable(tx_data))); // R8
endmodule

// File: rtl/pkt_mm_bridge.sv
module pkt_mm_bridge
   import pmb_pkg::*;
#(
   parameter int NFUNC    = 2,
   parameter int DW       = 32,
   parameter int DATA_W   = 128,
   parameter int FSEL_BIT = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic              rx_sop,
   input  logic              rx_eop,
   input  logic [DATA_W-1:0] rx_data,
   output logic [NFUNC-1:0]  mm_sel,
   output logic [NFUNC-1:0]  mm_wr,
   output logic [NFUNC-1:0]  mm_rd,
   output logic [DW-1:0]     mm_addr,
   output logic [DW-1:0]     mm_wdata,
   input  logic [DW-1:0]     mm_rdata,
   input  logic              mm_rdvalid,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_sop,
   output logic              tx_eop,
   output logic [DATA_W-1:0] tx_data
);
   localparam int FIDX_W = $clog2(NFUNC);

   generate
      if (NFUNC < 2 || (NFUNC & (NFUNC - 1)) != 0) begin : g_bad_nfunc
         $error("pkt_mm_bridge: function count must be a power of two, at least 2");
      end
      if (DW < 16) begin : g_bad_dw
         $error("pkt_mm_bridge: dword too narrow for the header");
      end
   endgenerate

   pmb_op_e           dec_op;
   logic [FIDX_W-1:0] dec_fidx;
   logic [DW-1:0]     dec_tag, dec_addr, dec_wdata;
   logic              take, cap_req, cap_rd, cpl_valid;

   assign take = rx_valid && rx_sop && rx_ready;

   pmb_decode #(.DW(DW), .DATA_W(DATA_W), .FSEL_BIT(FSEL_BIT), .FIDX_W(FIDX_W)) u_dec (
      .beat  (rx_data),
      .eop   (rx_eop),
      .op    (dec_op),
      .fidx  (dec_fidx),
      .tag   (dec_tag),
      .addr  (dec_addr),
      .wdata (dec_wdata)
   );

   pmb_ctrl #(.NFUNC(NFUNC), .FIDX_W(FIDX_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .op        (dec_op),
      .fidx      (dec_fidx),
      .rd_valid  (mm_rdvalid),
      .tx_ready  (tx_ready),
      .idle      (rx_ready),
      .cap_req   (cap_req),
      .cap_rd    (cap_rd),
      .cpl_valid (cpl_valid),
      .sel_vec   (mm_sel),
      .wr_vec    (mm_wr),
      .rd_vec    (mm_rd)
   );

   pmb_cpl #(.DW(DW), .DATA_W(DATA_W)) u_cpl (
      .clk       (clk),
      .rst       (rst),
      .cap_req   (cap_req),
      .cap_rd    (cap_rd),
      .tag_in    (dec_tag),
      .addr_in   (dec_addr),
      .wdata_in  (dec_wdata),
      .rdata_in  (mm_rdata),
      .cpl_valid (cpl_valid),
      .tx_ready  (tx_ready),
      .addr_q    (mm_addr),
      .wdata_q   (mm_wdata),
      .tx_data   (tx_data)
   );

   assign tx_valid = cpl_valid;
   assign tx_sop   = cpl_valid;
   assign tx_eop   = cpl_valid;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mm_sel)); // R3
   AST_WR_IN_SEL: assert property (@(posedge clk) disable iff (rst)
      ((mm_wr | mm_rd) & ~mm_sel) == '0); // R3
   AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
      ((|mm_sel) || tx_valid) |-> !rx_ready); // R1
   AST_CPL_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_valid) |-> $past(mm_rdvalid)); // R6
   AST_TX_HOLD_READY: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> (tx_valid && !rx_ready)); // R8
endmodule

// File: tb/sim_pkt_mm_bridge.sv
module sim_pkt_mm_bridge;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [127:0] rx_data = '0;
   logic         rx_ready;
   logic [1:0]   mm_sel, mm_wr, mm_rd;
   logic [31:0]  mm_addr, mm_wdata;
   logic [31:0]  mm_rdata = '0;
   logic         mm_rdvalid = 1'b0;
   logic         tx_valid, tx_sop, tx_eop;
   logic         tx_ready = 1'b1;
   logic [127:0] tx_data;

   always #10 clk = ~clk;

   pkt_mm_bridge u0 (
      .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
      .mm_sel(mm_sel), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
      .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_rdvalid(mm_rdvalid),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop),
      .tx_eop(tx_eop), .tx_data(tx_data)
   );

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done = 0;

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 write, 2 read strobe, 3 waiting, 4 completion
   int          ph = 0;
   int          fn = 0;
   logic [31:0] m_addr, m_wdata, m_tag, m_rd;

   always @(posedge clk) begin
      if (rst) ph = 0;
      else begin
         case (ph)
            0: if (rx_valid && rx_sop) begin
                  if (rx_eop && rx_data[23:0] == 24'h1 &&
                      (rx_data[31:24] == 8'h40 || rx_data[31:24] == 8'h00)) begin
                     ph      = (rx_data[31:24] == 8'h40) ? 1 : 2;
                     fn      = int'(rx_data[84]);
                     m_tag   = rx_data[63:32];
                     m_addr  = rx_data[95:64];
                     m_wdata = rx_data[127:96];
                  end
               end
            1: ph = 0;
            2: ph = 3;
            3: if (mm_rdvalid) begin m_rd = mm_rdata; ph = 4; end
            4: if (tx_ready) ph = 0;
            default: ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [1:0] onef;
         onef = 2'(1 << fn);
         check("R1 R9 R11 rx_ready", 128'(rx_ready), 128'(ph == 0));
         check("R3 R5 mm_sel", 128'(mm_sel), 128'((ph >= 1 && ph <= 3) ? onef : 2'b00));
         check("R4 mm_wr", 128'(mm_wr), 128'((ph == 1) ? onef : 2'b00));
         check("R5 mm_rd", 128'(mm_rd), 128'((ph == 2) ? onef : 2'b00));
         if (ph == 1) check("R2 R4 mm_wdata", 128'(mm_wdata), 128'(m_wdata));
         if (ph >= 1 && ph <= 3) check("R2 mm_addr", 128'(mm_addr), 128'(m_addr));
         check("R7 R8 tx_valid", 128'(tx_valid), 128'(ph == 4));
         check("R7 tx_sop/eop", 128'({tx_sop, tx_eop}), 128'((ph == 4) ? 2'b11 : 2'b00));
         if (ph == 4) check("R6 R7 tx_data", tx_data, {m_rd, m_tag, 32'h0, 32'h4A000001});
      end
   end

   // target function model: answers a read strobe after lat cycles
   int          lat = 1;
   int          cnt = 0;
   bit          spur = 0;
   logic [31:0] rd_pat = 32'hC0DE_0100;

   always @(negedge clk) begin
      mm_rdvalid <= 1'b0;
      if (spur) begin
         mm_rdvalid <= 1'b1;
         mm_rdata   <= 32'hBAD0_BAD0;
         spur = 0;
      end else if (|mm_rd) begin
         cnt = lat;
      end else if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            mm_rdvalid <= 1'b1;
            rd_pat = rd_pat + 32'h11;
            mm_rdata <= rd_pat;
         end
      end
   end

   task automatic send(input logic [7:0] code, input logic [23:0] low,
                       input logic [31:0] tag, input logic [31:0] addr,
                       input logic [31:0] wd, input logic sop, input logic eop);
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1; rx_sop = sop; rx_eop = eop;
      rx_data  = {wd, addr, tag, code, low};
      @(negedge clk);
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
      rx_data  = '0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset rx_ready", 128'(rx_ready), 128'(1));
      check("R10 reset strobes", 128'({mm_sel, mm_wr, mm_rd, tx_valid}), 128'(0));
      rst = 1'b0;

      // R4: writes to both functions (R3 address bit 20)
      send(8'h40, 24'h1, 32'h0000_1A01, 32'h0010_0040, 32'hDEAD_BEEF, 1, 1);
      send(8'h40, 24'h1, 32'h0000_1A02, 32'h000F_FFF0, 32'h1234_5678, 1, 1);
      settle(3);
      // R5 R6 R7: read from function 1, latency 1
      send(8'h00, 24'h1, 32'h0100_2B03, 32'h0010_0008, 32'h0, 1, 1);
      settle(6);
      // R6: read from function 0, latency 3
      lat = 3;
      send(8'h00, 24'h1, 32'h0200_2B04, 32'h0000_0004, 32'h0, 1, 1);
      settle(9);
      // R8: completion back-pressure
      lat = 1;
      tx_ready = 1'b0;
      send(8'h00, 24'h1, 32'h0300_2B05, 32'h0030_0000, 32'h0, 1, 1);
      settle(8);
      tx_ready = 1'b1;
      settle(3);
      // R9: unknown code, bad length, missing eop
      send(8'h20, 24'h1, 32'h0, 32'h0010_0000, 32'h5555_5555, 1, 1);
      send(8'h40, 24'h2, 32'h0, 32'h0010_0000, 32'h6666_6666, 1, 1);
      send(8'h00, 24'h1, 32'h0, 32'h0010_0000, 32'h0, 1, 0);
      settle(2);
      // R11: beat without sop
      send(8'h40, 24'h1, 32'h0, 32'h0010_0000, 32'h7777_7777, 0, 1);
      settle(2);
      // R6: stray read-valid while idle
      spur = 1;
      settle(3);
      // back-to-back write then read on function 1
      send(8'h40, 24'h1, 32'h0000_3C06, 32'h0010_0100, 32'hA5A5_5A5A, 1, 1);
      send(8'h00, 24'h1, 32'h0400_3C07, 32'h0010_0100, 32'h0, 1, 1);
      settle(6);
      // R10: reset in the middle of a read
      lat = 4;
      send(8'h00, 24'h1, 32'h0500_3C08, 32'h0000_0200, 32'h0, 1, 1);
      settle(1);
      rst = 1'b1;
      settle(2);
      check("R10 mid-read reset", 128'({rx_ready, mm_sel, mm_rd, tx_valid}), 128'(6'b100000));
      rst = 1'b0;
      settle(8);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule